// File: doc/BRIEF.md
# Pipelined Bucket Accumulation Scheduler

This block sums a stream of points into a table of buckets. Every input beat carries a scalar and a point. The bucket index is the slice of the scalar that the current window selects. Each accepted point is added into its bucket by a combine unit. The unit takes a new operation every clock and returns the result a fixed number of cycles later. The combine operation is a stand-in: a modular addition on a narrow word.

A point may target a bucket that already has an addition in flight. Such a point is not stalled. It is parked in a small deferral queue and reissued once that bucket's result has been written back, so the combine unit keeps taking new work. The head of the queue goes first whenever its bucket is free. Otherwise the new input goes. A cycle with nothing to issue sends a bubble. The first point that lands in an empty bucket is stored as it is.

A window begins with a start pulse and ends with a flush pulse. Done is raised once all work has drained. The buckets are then read through a combinational read port.

Top module: `bucket_accum_sched`

## Requirements
- R1: After reset, in_ready_o is 1, done_o is 0 and every bucket reads 0 on rd_data_o.
- R2: The bucket index of a beat is in_scalar_i[win_i*IDX_W +: IDX_W]. The other scalar bits have no effect.
- R3: After done_o, each bucket reads the sum modulo MOD of every point sent to it during the window.
- R4: A bucket that received no point in the window reads 0. The first point written to an empty bucket is stored unchanged.
- R5: A stream to distinct buckets is accepted on every cycle with no deassertion of in_ready_o.
- R6: A point whose bucket is busy is deferred without stalling the input. With fewer pending conflicts than DEFER_DEPTH, in_ready_o stays 1.
- R7: When the deferral queue is full, in_ready_o is 0. The bucket's sum still reaches its final value. A back-to-back burst to one bucket is accepted for exactly DEFER_DEPTH+1 cycles before the first deassertion, provided LAT exceeds DEFER_DEPTH+1.
- R8: done_o is 0 while work is queued or in flight after flush_i. It rises once everything has drained and then stays 1 until start_i. in_ready_o is 0 after flush_i.
- R9: start_i empties all buckets, so each reads 0 until written in the new window.
- R10: A point accepted into an empty bucket at a clock edge becomes visible on rd_data_o after exactly LAT further rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a window: empties the buckets and clears the end state |
| win_i | input | WIN_W | Window number that selects the scalar slice |
| in_valid_i | input | 1 | Input beat valid |
| in_ready_o | output | 1 | Input beat accepted when high together with valid |
| in_scalar_i | input | NUM_WIN*IDX_W | Scalar that carries the bucket index |
| in_pt_i | input | DATA_W | Point value, below MOD |
| flush_i | input | 1 | Marks the end of input for the window |
| done_o | output | 1 | All accumulation finished |
| rd_idx_i | input | IDX_W | Bucket read address |
| rd_data_o | output | DATA_W | Bucket content, 0 when empty |

## Verification
A busy flag left stuck shows as a bucket that never drains. done_o then fails to rise within a bounded number of cycles. A busy flag missed lets two additions to one bucket overlap, and one of the contributions is lost. That loss appears at the read port as a wrong sum once the window ends. The streams therefore repeat the same bucket heavily and use values near the modulus. A defect in queue order or priority shows either as in_ready_o deasserting at the wrong cycle during a same-bucket burst or as a missing point in the final sums. A wrong writeback timing shifts the LAT-edge visibility of a single point.

// File: rtl/bas_pkg.sv
package bas_pkg;
  typedef enum logic [1:0] {SRC_NONE, SRC_DEFER, SRC_INPUT} issue_src_e;
endpackage

// File: rtl/bas_defer_fifo.sv
module bas_defer_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign dout_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= nxt(wp_q);
      if (pop_i)  rp_q <= nxt(rp_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i));
  assert_no_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/bas_combine_pipe.sv
module bas_combine_pipe #(
  parameter int          IDX_W  = 10,
  parameter int          DATA_W = 16,
  parameter int unsigned MOD    = 65521,
  parameter int          LAT    = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_v_i,
  input  logic [IDX_W-1:0]  in_idx_i,
  input  logic [DATA_W-1:0] in_pt_i,
  input  logic [DATA_W-1:0] base_i,
  input  logic              base_vld_i,
  output logic              out_v_o,
  output logic [IDX_W-1:0]  out_idx_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              busy_o
);
  localparam logic [DATA_W:0] MOD_W = (DATA_W + 1)'(MOD);

  logic [LAT-1:0]    v_q;
  logic [IDX_W-1:0]  idx_q [LAT];
  logic [DATA_W-1:0] dat_q [LAT];
  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] res;

  // stand-in combine: modular add, empty bucket takes the point as is
  always_comb begin
    sum = {1'b0, base_i} + {1'b0, in_pt_i};
    if (sum >= MOD_W) sum = sum - MOD_W;
    res = base_vld_i ? sum[DATA_W-1:0] : in_pt_i;
  end

  always_ff @(posedge clk_i) begin
    idx_q[0] <= in_idx_i;
    dat_q[0] <= res;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v_q <= '0;
    else         v_q <= {v_q[LAT-2:0], in_v_i};
  end

  for (genvar k = 1; k < LAT; k++) begin : g_stage
    always_ff @(posedge clk_i) begin
      idx_q[k] <= idx_q[k-1];
      dat_q[k] <= dat_q[k-1];
    end
  end

  assign out_v_o    = v_q[LAT-1];
  assign out_idx_o  = idx_q[LAT-1];
  assign out_data_o = dat_q[LAT-1];
  assign busy_o     = |v_q;
endmodule

// File: rtl/bas_bucket_store.sv
module bas_bucket_store #(
  parameter int IDX_W  = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [IDX_W-1:0]  busy_a_idx_i,
  output logic              busy_a_o,
  input  logic [IDX_W-1:0]  busy_b_idx_i,
  output logic              busy_b_o,
  input  logic              issue_v_i,
  input  logic [IDX_W-1:0]  issue_idx_i,
  output logic [DATA_W-1:0] acc_data_o,
  output logic              acc_vld_o,
  input  logic              wb_v_i,
  input  logic [IDX_W-1:0]  wb_idx_i,
  input  logic [DATA_W-1:0] wb_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int NB = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [NB];
  logic [NB-1:0]     vld_q;
  logic [NB-1:0]     busy_q;

  assign busy_a_o   = busy_q[busy_a_idx_i];
  assign busy_b_o   = busy_q[busy_b_idx_i];
  assign acc_data_o = mem_q[issue_idx_i];
  assign acc_vld_o  = vld_q[issue_idx_i];
  assign rd_data_o  = vld_q[rd_idx_i] ? mem_q[rd_idx_i] : '0;

  always_ff @(posedge clk_i) begin
    if (wb_v_i) mem_q[wb_idx_i] <= wb_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      busy_q <= '0;
    end else begin
      if (clear_i)     vld_q <= '0;
      else if (wb_v_i) vld_q[wb_idx_i] <= 1'b1;
      if (wb_v_i)    busy_q[wb_idx_i]    <= 1'b0;
      if (issue_v_i) busy_q[issue_idx_i] <= 1'b1;
    end
  end

  assert_issue_free_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_v_i |-> !busy_q[issue_idx_i]);
  assert_wb_inflight_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_v_i |-> busy_q[wb_idx_i]);
endmodule

// File: rtl/bucket_accum_sched.sv
module bucket_accum_sched
  import bas_pkg::*;
#(
  parameter int          IDX_W       = 10,
  parameter int          DATA_W      = 16,
  parameter int unsigned MOD         = 65521,
  parameter int          LAT         = 100,
  parameter int          DEFER_DEPTH = 16,
  parameter int          NUM_WIN     = 16,
  localparam int         WIN_W       = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int         SC_W        = NUM_WIN * IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WIN_W-1:0]  win_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [SC_W-1:0]   in_scalar_i,
  input  logic [DATA_W-1:0] in_pt_i,
  input  logic              flush_i,
  output logic              done_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int EW = IDX_W + DATA_W;

  logic [IDX_W-1:0]  in_idx, head_idx, iss_idx, wb_idx;
  logic [DATA_W-1:0] head_pt, iss_pt, acc_data, wb_data;
  logic [EW-1:0]     head_ent;
  logic              fifo_empty, fifo_full, head_busy, in_busy;
  logic              head_ok, in_fire, push, iss_v, acc_vld, wb_v, pipe_busy;
  logic              ended_q;
  issue_src_e        src;

  assign in_idx              = in_scalar_i[win_i*IDX_W +: IDX_W];
  assign {head_idx, head_pt} = head_ent;

  assign in_ready_o = !fifo_full && !ended_q;
  assign in_fire    = in_valid_i && in_ready_o;
  assign head_ok    = !fifo_empty && !head_busy;

  // deferred head first, then a fresh point whose bucket is idle
  always_comb begin
    if (head_ok)                src = SRC_DEFER;
    else if (in_fire && !in_busy) src = SRC_INPUT;
    else                        src = SRC_NONE;
  end

  assign push    = in_fire && (head_ok || in_busy);
  assign iss_v   = (src != SRC_NONE);
  assign iss_idx = (src == SRC_DEFER) ? head_idx : in_idx;
  assign iss_pt  = (src == SRC_DEFER) ? head_pt  : in_pt_i;

  bas_defer_fifo #(.W(EW), .DEPTH(DEFER_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .din_i   ({in_idx, in_pt_i}),
    .pop_i   (head_ok),
    .dout_o  (head_ent),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  bas_bucket_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (start_i),
    .busy_a_idx_i (head_idx),
    .busy_a_o     (head_busy),
    .busy_b_idx_i (in_idx),
    .busy_b_o     (in_busy),
    .issue_v_i    (iss_v),
    .issue_idx_i  (iss_idx),
    .acc_data_o   (acc_data),
    .acc_vld_o    (acc_vld),
    .wb_v_i       (wb_v),
    .wb_idx_i     (wb_idx),
    .wb_data_i    (wb_data),
    .rd_idx_i     (rd_idx_i),
    .rd_data_o    (rd_data_o)
  );

  bas_combine_pipe #(.IDX_W(IDX_W), .DATA_W(DATA_W), .MOD(MOD), .LAT(LAT)) u_pipe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_v_i     (iss_v),
    .in_idx_i   (iss_idx),
    .in_pt_i    (iss_pt),
    .base_i     (acc_data),
    .base_vld_i (acc_vld),
    .out_v_o    (wb_v),
    .out_idx_o  (wb_idx),
    .out_data_o (wb_data),
    .busy_o     (pipe_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ended_q <= 1'b0;
    else if (start_i) ended_q <= 1'b0;
    else if (flush_i) ended_q <= 1'b1;
  end

  assign done_o = ended_q && fifo_empty && !pipe_busy;

  assert_done_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
endmodule

// File: tb/tb_bucket_accum_sched.sv
module tb_bucket_accum_sched;
  localparam int IDX_W = 4, DATA_W = 16, LAT = 8, DEPTH = 4, NWIN = 4;
  localparam int unsigned MOD = 65521;
  localparam int NB = 1 << IDX_W;

  logic clk = 0, rst_n = 0, start = 0, flush = 0, in_valid = 0;
  logic [1:0] win = '0;
  logic [NWIN*IDX_W-1:0] in_scalar = '0;
  logic [DATA_W-1:0] in_pt = '0, rd_data;
  logic [IDX_W-1:0] rd_idx = '0;
  logic in_ready, done;

  int checks = 0, fails = 0, stalls = 0;
  int unsigned ref_sum [NB];
  int unsigned seed = 32'h1234_5678;

  always #5 clk = ~clk;

  bucket_accum_sched #(.IDX_W(IDX_W), .DATA_W(DATA_W), .MOD(MOD), .LAT(LAT),
                       .DEFER_DEPTH(DEPTH), .NUM_WIN(NWIN)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .win_i(win),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_scalar_i(in_scalar),
    .in_pt_i(in_pt), .flush_i(flush), .done_o(done),
    .rd_idx_i(rd_idx), .rd_data_o(rd_data));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  task automatic set_beat(input int idx, input int pt);
    logic [NWIN*IDX_W-1:0] s;
    s = 16'hA5C3;
    s[win*IDX_W +: IDX_W] = IDX_W'(idx);
    in_scalar = s;
    in_pt = DATA_W'(pt);
  endtask

  task automatic send(input int idx, input int pt);
    set_beat(idx, pt);
    in_valid = 1;
    while (!in_ready) begin stalls++; @(posedge clk); #1; end
    @(posedge clk); #1;
    in_valid = 0;
    ref_sum[idx] = (ref_sum[idx] + pt) % MOD;
  endtask

  task automatic open_win(input int w);
    @(negedge clk);
    win = 2'(w); start = 1;
    @(negedge clk);
    start = 0;
    for (int b = 0; b < NB; b++) ref_sum[b] = 0;
  endtask

  task automatic flush_wait(input string req);
    int n;
    flush = 1;
    @(posedge clk); #1;
    flush = 0;
    n = 0;
    while (!done && n < 1000) begin @(posedge clk); #1; n++; end
    chk(done == 1, req, done, 1);
  endtask

  task automatic check_all(input string req);
    for (int b = 0; b < NB; b++) begin
      rd_idx = IDX_W'(b); #1;
      chk(rd_data == DATA_W'(ref_sum[b]), req, rd_data, ref_sum[b]);
    end
  endtask

  task automatic t_reset;
    chk(in_ready == 1, "R1", in_ready, 1);
    chk(done == 0, "R1", done, 0);
    rd_idx = 5; #1;
    chk(rd_data == 0, "R1", rd_data, 0);
  endtask

  task automatic t_latency;
    open_win(0);
    send(7, 1234);
    repeat (LAT - 1) @(posedge clk);
    #1; rd_idx = 7; #1;
    chk(rd_data == 0, "R10", rd_data, 0);
    @(posedge clk); #2;
    chk(rd_data == 1234, "R10", rd_data, 1234);  // R4 first point stored as is
    flush_wait("R8");
    check_all("R4");
  endtask

  task automatic t_distinct;
    open_win(1);
    stalls = 0;
    for (int b = 0; b < NB; b++) send(b, b * 1000 + 17);
    chk(stalls == 0, "R5", stalls, 0);
    flush_wait("R8");
    check_all("R5");
  endtask

  task automatic t_slice;
    open_win(3);
    send(9, 4242);
    send(9, 58);
    flush_wait("R8");
    check_all("R2");
  endtask

  task automatic t_conflict;
    open_win(0);
    stalls = 0;
    send(2, 100); send(2, 200); send(5, 300); send(6, 400);
    send(2, 500); send(9, 600); send(10, 700);
    chk(stalls == 0, "R6", stalls, 0);
    flush_wait("R8");
    check_all("R6");
  endtask

  task automatic t_full;
    int acc;
    open_win(2);
    set_beat(3, 111);
    in_valid = 1;
    acc = 0;
    while (in_ready && acc < 20) begin @(posedge clk); #1; acc++; end
    in_valid = 0;
    chk(acc == DEPTH + 1, "R7", acc, DEPTH + 1);
    ref_sum[3] = (ref_sum[3] + acc * 111) % MOD;
    for (int i = 0; i < 20; i++) send((i % 3 == 0) ? 4 : 3, 900 + i);
    flush_wait("R8");
    check_all("R7");
  endtask

  task automatic t_heavy;
    int unsigned r;
    open_win(1);
    for (int i = 0; i < 200; i++) begin
      r = rnd();
      send((r % 4 == 0) ? int'(r % NB) : 1, int'(MOD - 1 - (r % 50)));
    end
    flush = 1;
    @(posedge clk); #1;
    flush = 0;
    chk(done == 0, "R8", done, 0);
    chk(in_ready == 0, "R8", in_ready, 0);
    flush_wait("R8");
    repeat (5) @(posedge clk);
    #1;
    chk(done == 1, "R8", done, 1);
    check_all("R3");
  endtask

  task automatic t_window;
    open_win(2);
    check_all("R9");
    send(0, 77); send(0, 23); send(15, 5);
    flush_wait("R8");
    check_all("R9");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    @(negedge clk);
    t_reset();
    t_latency();
    t_distinct();
    t_slice();
    t_conflict();
    t_full();
    t_heavy();
    t_window();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule